// File: doc/BRIEF.md
# Bitvector Rank and Select Unit

This block answers the two basic queries of succinct data structures on a single data word. A rank query takes an index n and returns how many set bits lie strictly below position n. A select query takes an ordinal n and returns the bit position of the n-th set bit, counting from zero.

Rank masks off every position at or above n and counts what remains with a pairwise summation tree. Adjacent bits are summed into 2-bit fields, adjacent 2-bit fields into 4-bit fields, and so on until one field spans the whole word. Select does not scan the word. It runs a bit-deposit datapath with the operand roles swapped: the data word acts as the deposit mask and the one-hot value 1<<n is deposited through it. At most one bit survives, and a trailing-zero encoder turns that bit into a position. If no bit survives, the answer does not exist.

A query is presented with a valid strobe. The answer appears on the registered outputs exactly one cycle later. Larger structures that span several words are built from this unit by a surrounding directory, which is not part of this block.

Top module: `bitRankSelect`

## Requirements
- R1: With inOp = 0 (rank) and inIndex = n where n <= W, the result one cycle later is the number of 1 bits of inWord at positions 0 to n-1, so rank(0) = 0, and outNotFound is 0.
- R2: A rank query with inIndex >= W returns the population count of the whole of inWord, with outNotFound 0.
- R3: With inOp = 1 (select) and inIndex = n, when inWord holds more than n set bits, the result is the position p such that inWord[p] = 1 and exactly n set bits lie below p (select(0) is the lowest set bit), with outNotFound 0.
- R4: A select query with inIndex greater than or equal to the population count of inWord sets outNotFound to 1 and returns 0. This covers an all-zero word and any index >= W.
- R5: outValid is 1 in exactly the cycle that follows a cycle in which inValid was 1.
- R6: While inValid is 0, outResult and outNotFound keep their values, whatever inWord, inIndex and inOp do.
- R7: After reset, outValid, outResult and outNotFound are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A query is presented this cycle |
| inOp | input | 1 | 0 selects rank, 1 selects select |
| inWord | input | W | Data word that is queried |
| inIndex | input | IDXW | Rank position or select ordinal n |
| outValid | output | 1 | The result registers hold a new answer |
| outResult | output | IDXW | Count (rank) or bit position (select) |
| outNotFound | output | 1 | The select ordinal exceeds the number of set bits |

## Verification
The bench builds the unit with W = 8, which makes IDXW = 4. At this width every one of the 256 data words can be paired with every encodable index from 0 to 15, under both opcodes. The sweep therefore covers rank at 0, at W and above W. It also covers select on the empty word, on the full word, at the last set bit and one past it. Between queries, the bench changes the inputs while inValid is low and confirms that the held outputs do not move.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic {
    OP_RANK   = 1'b0,
    OP_SELECT = 1'b1
  } rsOp_e;

  typedef struct packed {
    logic loadRank;
    logic loadSelect;
  } rsStrobe_t;

endpackage

// File: rtl/rs_popcount.sv
module rs_popcount #(
  parameter int W    = 64,
  parameter int OUTW = $clog2(W) + 1
) (
  input  logic [W-1:0]    vec,
  output logic [OUTW-1:0] count
);
  localparam int LEVELS = $clog2(W);

  function automatic logic [W-1:0] fieldMask(input int lvl);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) begin
      m[i] = ((i % (2 << lvl)) < (1 << lvl));
    end
    return m;
  endfunction

  logic [W-1:0] stage [0:LEVELS];
  logic         unusedBits;

  assign stage[0] = vec;

  // Each level adds neighbouring fields into fields twice as wide.
  for (genvar l = 0; l < LEVELS; l++) begin : gLevel
    localparam logic [W-1:0] M = fieldMask(l);
    assign stage[l+1] = (stage[l] & M) + ((stage[l] >> (1 << l)) & M);
  end

  assign count      = stage[LEVELS][OUTW-1:0];
  assign unusedBits = ^stage[LEVELS][W-1:OUTW];
endmodule

// File: rtl/rs_deposit.sv
module rs_deposit #(
  parameter int W = 64
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  output logic [W-1:0] result
);
  localparam int LW = $clog2(W);

  logic [LW-1:0] prefix [W];

  // prefix[i] is the number of mask ones below position i.
  always_comb begin
    logic [LW-1:0] running;
    running = '0;
    for (int i = 0; i < W; i++) begin
      prefix[i] = running;
      running   = running + LW'(mask[i]);
    end
  end

  for (genvar i = 0; i < W; i++) begin : gLane
    assign result[i] = mask[i] & value[prefix[i]];
  end
endmodule

// File: rtl/rs_tzc.sv
module rs_tzc #(
  parameter int W = 64
) (
  input  logic [W-1:0]         vec,
  output logic [$clog2(W)-1:0] pos,
  output logic                 found
);
  localparam int LW = $clog2(W);

  // Scan from the top down, so that the lowest set bit wins.
  always_comb begin
    pos = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) pos = LW'(i);
    end
  end

  assign found = |vec;
endmodule

// File: rtl/rs_control.sv
module rs_control
  import rs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inOp,
  output rsStrobe_t strobes,
  output logic      outValid
);
  rsOp_e op;

  assign op                 = rsOp_e'(inOp);
  assign strobes.loadRank   = inValid && (op == OP_RANK);
  assign strobes.loadSelect = inValid && (op == OP_SELECT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int W    = 64,
  parameter int IDXW = $clog2(W) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  rsStrobe_t       strobes,
  input  logic [W-1:0]    word,
  input  logic [IDXW-1:0] index,
  output logic [IDXW-1:0] result,
  output logic            notFound
);
  localparam int LW = $clog2(W);

  logic [W-1:0]    belowMask;
  logic [IDXW-1:0] rankCount;
  logic [W-1:0]    oneHot;
  logic [W-1:0]    deposited;
  logic [LW-1:0]   selPos;
  logic            selFound;

  // Rank path: keep only the positions below the index.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      belowMask[i] = (IDXW'(i) < index);
    end
  end

  rs_popcount #(.W(W), .OUTW(IDXW)) uPop (
    .vec   (word & belowMask),
    .count (rankCount)
  );

  // Select path: deposit 1<<n through the data word, which acts as the mask.
  assign oneHot = (index < IDXW'(W)) ? (W'(1) << index[LW-1:0]) : '0;

  rs_deposit #(.W(W)) uDep (
    .value  (oneHot),
    .mask   (word),
    .result (deposited)
  );

  rs_tzc #(.W(W)) uTzc (
    .vec   (deposited),
    .pos   (selPos),
    .found (selFound)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      notFound <= 1'b0;
    end else if (strobes.loadRank) begin
      result   <= rankCount;
      notFound <= 1'b0;
    end else if (strobes.loadSelect) begin
      result   <= selFound ? IDXW'(selPos) : '0;
      notFound <= !selFound;
    end
  end
endmodule

// File: rtl/bitRankSelect.sv
module bitRankSelect
  import rs_pkg::*;
#(
  parameter int W    = 64,
  parameter int IDXW = $clog2(W) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inOp,
  input  logic [W-1:0]    inWord,
  input  logic [IDXW-1:0] inIndex,
  output logic            outValid,
  output logic [IDXW-1:0] outResult,
  output logic            outNotFound
);
  rsStrobe_t strobes;

  rs_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inOp     (inOp),
    .strobes  (strobes),
    .outValid (outValid)
  );

  rs_datapath #(.W(W), .IDXW(IDXW)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .word     (inWord),
    .index    (inIndex),
    .result   (outResult),
    .notFound (outNotFound)
  );
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int W    = 64,
  parameter int IDXW = $clog2(W) + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            inOp,
  input logic [W-1:0]    inWord,
  input logic [IDXW-1:0] inIndex,
  input logic            outValid,
  input logic [IDXW-1:0] outResult,
  input logic            outNotFound
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R5
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R5
  AST_RANK_NEVER_MISSES: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inOp) |=> !outNotFound); // R1
  AST_RANK_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inOp) |=> (outResult <= $past(inIndex))); // R1
  AST_SELECT_HITS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp) |=> (outNotFound || ((($past(inWord) >> outResult) & W'(1)) != '0))); // R3
  AST_SELECT_NOT_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp) |=> (outNotFound || (outResult >= $past(inIndex)))); // R3
  AST_MISS_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outNotFound |-> (outResult == '0)); // R4
  AST_SELECT_WIDE_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp && (inIndex >= IDXW'(W))) |=> outNotFound); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && $stable(outNotFound))); // R6
endmodule

bind bitRankSelect rs_checker #(.W(W), .IDXW(IDXW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inOp        (inOp),
  .inWord      (inWord),
  .inIndex     (inIndex),
  .outValid    (outValid),
  .outResult   (outResult),
  .outNotFound (outNotFound)
);

// File: tb/bitRankSelect_test.sv
module bitRankSelect_test;
  localparam int W          = 8;
  localparam int IDXW       = 4;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic            inOp = 1'b0;
  logic [W-1:0]    inWord = '0;
  logic [IDXW-1:0] inIndex = '0;
  logic            outValid;
  logic [IDXW-1:0] outResult;
  logic            outNotFound;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bitRankSelect #(.W(W), .IDXW(IDXW)) uut (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inOp        (inOp),
    .inWord      (inWord),
    .inIndex     (inIndex),
    .outValid    (outValid),
    .outResult   (outResult),
    .outNotFound (outNotFound)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int refRank(input int word, input int n);
    int c = 0;
    for (int i = 0; i < W; i++) if (i < n && word[i]) c++;
    return c;
  endfunction

  // Returns -1 when the n-th set bit does not exist.
  function automatic int refSelect(input int word, input int n);
    int seen = 0;
    for (int i = 0; i < W; i++) begin
      if (word[i]) begin
        if (seen == n) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic runQuery(input bit op, input int word, input int n);
    @(negedge clk);
    inValid = 1'b1;
    inOp    = op;
    inWord  = W'(word);
    inIndex = IDXW'(n);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R5 outValid after query", int'(outValid), 1);
    if (!op) begin
      int exp = refRank(word, n);
      if (n >= W) check(outResult == IDXW'(exp) && !outNotFound, "R2 rank past width", int'(outResult), exp);
      else        check(outResult == IDXW'(exp) && !outNotFound, "R1 rank", int'(outResult), exp);
    end else begin
      int exp = refSelect(word, n);
      if (exp < 0) check(outNotFound && outResult == '0, "R4 select miss", int'({outNotFound, outResult}), 1 << IDXW);
      else         check(!outNotFound && outResult == IDXW'(exp), "R3 select", int'(outResult), exp);
    end
  endtask

  task automatic checkHold();
    logic [IDXW-1:0] r;
    logic            nf;
    r  = outResult;
    nf = outNotFound;
    @(negedge clk);
    inOp    = ~inOp;
    inWord  = ~inWord;
    inIndex = inIndex + 1'b1;
    @(negedge clk);
    check(!outValid, "R5 outValid idle", int'(outValid), 0);
    check(outResult == r && outNotFound == nf, "R6 hold while idle", int'({outNotFound, outResult}), int'({nf, r}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && outResult == '0 && !outNotFound, "R7 reset state",
          int'({outValid, outNotFound, outResult}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid, "R7 idle after reset", int'(outValid), 0);
    for (int w = 0; w < (1 << W); w++) begin
      for (int n = 0; n < (1 << IDXW); n++) begin
        runQuery(1'b0, w, n);
        runQuery(1'b1, w, n);
      end
      if (w % 16 == 0) checkHold();
    end
    // Directed corners: empty word, full word, last set bit and one past it.
    runQuery(1'b1, 0, 0);
    runQuery(1'b1, 8'hFF, W - 1);
    runQuery(1'b1, 8'h81, 1);
    runQuery(1'b1, 8'h81, 2);
    checkHold();
    runQuery(1'b0, 8'hFF, W);
    runQuery(1'b0, 8'hA5, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule